// File: doc/BRIEF.md
# Dual-Clock Shared-Array RAM with Per-Port Read Latency Choice

This block is a true dual-port synchronous memory. Two fully independent ports, each with its own clock, share one array of 18-bit words. Every word is split into two 9-bit lanes. Bits 17:9 form the upper lane and bits 8:0 form the lower lane. On every rising edge of its clock, each port captures an address, a read/write strobe, a pair of chip enables of opposite polarity and two active-low lane enables. Successive accesses may therefore go to any address in any order.

A per-port latency pin selects when read data appears. In flow-through mode, data appears right after the edge that captured the read. In pipelined mode, it appears one clock later, after an extra register stage.

Read data is not driven onto tri-state pins. Each port presents a data bus together with one valid flag per lane. A lane that is not valid drives zeros. There is no back-pressure: the outputs are plain registered flags with no ready input, so a consumer must take each word in the cycle it is shown. A per-port active-low output enable blanks the outputs combinationally, without waiting for a clock.

Top module: `dual_port_ram`

## Requirements
- R1: A port is selected only when its `ce0_n` is 0 and its `ce1` is 1. A deselected edge writes nothing and produces no read data, and the outputs go blank after that edge rather than at once.
- R2: With `pipe` = 0, a read captured at edge k shows its lane flags and data from edge k until edge k+1.
- R3: With `pipe` = 1, a read captured at edge k shows its lane flags and data from edge k+1 until edge k+2.
- R4: `lane_n[1]` controls bits 17:9 and `lane_n[0]` controls bits 8:0, both active low. A read shows `rvalid[i]` = 1 only for the lanes whose enables were 0 at the capture edge, and both flags are 0 when both enables are 1.
- R5: A selected edge with `rw` = 0 stores `wdata` into the addressed word, but only in the lanes whose `lane_n` bit is 0. The other lanes keep their old contents.
- R6: A write edge produces no read data: both lane flags are 0 for the slot of that edge.
- R7: While `oe_n` is 1, `rvalid` and `rdata` are all zero. The effect is immediate and needs no clock edge.
- R8: Any lane whose valid flag is 0 drives zeros on its 9 data bits.
- R9: A word written through one port is read back through the other port, with each port running on its own clock.
- R10: While a port's reset is low, both of its lane flags are 0.
- R11: A new address is captured on every edge, so back-to-back reads to non-sequential addresses each return their own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous active-low reset |
| pipe_a | input | 1 | Port A latency: 1 = pipelined, 0 = flow-through |
| ce0_n_a | input | 1 | Port A chip enable, active low |
| ce1_a | input | 1 | Port A chip enable, active high |
| rw_a | input | 1 | Port A 1 = read, 0 = write |
| lane_n_a | input | 2 | Port A lane enables, active low, bit 1 = upper lane |
| addr_a | input | AW | Port A word address |
| wdata_a | input | 18 | Port A write data |
| oe_n_a | input | 1 | Port A output enable, active low, combinational |
| rdata_a | output | 18 | Port A read data |
| rvalid_a | output | 2 | Port A per-lane valid flags |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous active-low reset |
| pipe_b | input | 1 | Port B latency: 1 = pipelined, 0 = flow-through |
| ce0_n_b | input | 1 | Port B chip enable, active low |
| ce1_b | input | 1 | Port B chip enable, active high |
| rw_b | input | 1 | Port B 1 = read, 0 = write |
| lane_n_b | input | 2 | Port B lane enables, active low, bit 1 = upper lane |
| addr_b | input | AW | Port B word address |
| wdata_b | input | 18 | Port B write data |
| oe_n_b | input | 1 | Port B output enable, active low, combinational |
| rdata_b | output | 18 | Port B read data |
| rvalid_b | output | 2 | Port B per-lane valid flags |

## Verification
Port A is driven with an uninterrupted stream of mixed operations, which checks every cycle slot against its expected value:
- full writes, then reads in scrambled address order;
- single-lane writes and reads;
- reads with both lanes off;
- each wrong chip-enable combination.

The same style of stream is repeated with the latency pin in each setting, so the stream exposes a data word shifted by one slot as well as a write or deselected edge that leaks data. A read followed at once by a deselect shows that blanking waits for the next edge. Toggling the output enable between clock edges shows that the blanking is combinational. Words written on one port and read on the other, under both latency settings, show that the array is shared.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;
endpackage

// File: rtl/dpr_store.sv
`timescale 1ns/1ps
// Shared array built from two single-writer halves. The stored word is the XOR
// of both halves, so each clock domain only ever writes its own half.
module dpr_store
  import dpr_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_a,
  input  logic [AW-1:0] addr_a,
  input  lane_t         wmask_a,
  input  word_t         wdata_a,
  output word_t         rword_a,
  input  logic          clk_b,
  input  logic [AW-1:0] addr_b,
  input  lane_t         wmask_b,
  input  word_t         wdata_b,
  output word_t         rword_b
);
  word_t half_a [DEPTH] = '{default: '0};
  word_t half_b [DEPTH] = '{default: '0};

  always_ff @(posedge clk_a) begin
    for (int l = 0; l < LANES; l++) begin
      if (wmask_a[l])
        half_a[addr_a][l*LANE_W +: LANE_W] <=
          wdata_a[l*LANE_W +: LANE_W] ^ half_b[addr_a][l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk_b) begin
    for (int l = 0; l < LANES; l++) begin
      if (wmask_b[l])
        half_b[addr_b][l*LANE_W +: LANE_W] <=
          wdata_b[l*LANE_W +: LANE_W] ^ half_a[addr_b][l*LANE_W +: LANE_W];
    end
  end

  assign rword_a = half_a[addr_a] ^ half_b[addr_a];
  assign rword_b = half_a[addr_b] ^ half_b[addr_b];
endmodule

// File: rtl/dpr_port.sv
`timescale 1ns/1ps
// Per-port control capture and the two read stages.
module dpr_port
  import dpr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce0_n,
  input  logic  ce1,
  input  logic  rw,
  input  lane_t lane_n,
  input  word_t rword,
  output lane_t wmask,
  output lane_t flow_v,
  output word_t flow_d,
  output lane_t pipe_v,
  output word_t pipe_d
);
  logic  sel;
  lane_t rd_lanes;

  assign sel      = ~ce0_n & ce1;
  assign wmask    = {LANES{sel & ~rw}} & ~lane_n;
  assign rd_lanes = {LANES{sel & rw}} & ~lane_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flow_v <= '0;
      flow_d <= '0;
      pipe_v <= '0;
      pipe_d <= '0;
    end else begin
      flow_v <= rd_lanes;
      flow_d <= rword;
      pipe_v <= flow_v;
      pipe_d <= flow_d;
    end
  end
endmodule

// File: rtl/dpr_outsel.sv
`timescale 1ns/1ps
// Latency choice, combinational output enable and lane zeroing.
module dpr_outsel
  import dpr_pkg::*;
(
  input  logic  pipe,
  input  logic  oe_n,
  input  lane_t flow_v,
  input  word_t flow_d,
  input  lane_t pipe_v,
  input  word_t pipe_d,
  output word_t rdata,
  output lane_t rvalid
);
  lane_t v_sel;
  word_t d_sel;

  assign v_sel  = pipe ? pipe_v : flow_v;
  assign d_sel  = pipe ? pipe_d : flow_d;
  assign rvalid = v_sel & {LANES{~oe_n}};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rdata[l*LANE_W +: LANE_W] = rvalid[l] ? d_sel[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/dual_port_ram.sv
`timescale 1ns/1ps
module dual_port_ram
  import dpr_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_a,
  input  logic          rst_a_n,
  input  logic          pipe_a,
  input  logic          ce0_n_a,
  input  logic          ce1_a,
  input  logic          rw_a,
  input  logic [1:0]    lane_n_a,
  input  logic [AW-1:0] addr_a,
  input  logic [17:0]   wdata_a,
  input  logic          oe_n_a,
  output logic [17:0]   rdata_a,
  output logic [1:0]    rvalid_a,
  input  logic          clk_b,
  input  logic          rst_b_n,
  input  logic          pipe_b,
  input  logic          ce0_n_b,
  input  logic          ce1_b,
  input  logic          rw_b,
  input  logic [1:0]    lane_n_b,
  input  logic [AW-1:0] addr_b,
  input  logic [17:0]   wdata_b,
  input  logic          oe_n_b,
  output logic [17:0]   rdata_b,
  output logic [1:0]    rvalid_b
);
  lane_t wm_a, wm_b, fv_a, fv_b, pv_a, pv_b;
  word_t rw_word_a, rw_word_b, fd_a, fd_b, pd_a, pd_b;

  dpr_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_a(clk_a), .addr_a(addr_a), .wmask_a(wm_a), .wdata_a(wdata_a), .rword_a(rw_word_a),
    .clk_b(clk_b), .addr_b(addr_b), .wmask_b(wm_b), .wdata_b(wdata_b), .rword_b(rw_word_b)
  );

  dpr_port u_port_a (
    .clk(clk_a), .rst_n(rst_a_n), .ce0_n(ce0_n_a), .ce1(ce1_a), .rw(rw_a),
    .lane_n(lane_n_a), .rword(rw_word_a), .wmask(wm_a),
    .flow_v(fv_a), .flow_d(fd_a), .pipe_v(pv_a), .pipe_d(pd_a)
  );

  dpr_port u_port_b (
    .clk(clk_b), .rst_n(rst_b_n), .ce0_n(ce0_n_b), .ce1(ce1_b), .rw(rw_b),
    .lane_n(lane_n_b), .rword(rw_word_b), .wmask(wm_b),
    .flow_v(fv_b), .flow_d(fd_b), .pipe_v(pv_b), .pipe_d(pd_b)
  );

  dpr_outsel u_out_a (
    .pipe(pipe_a), .oe_n(oe_n_a), .flow_v(fv_a), .flow_d(fd_a),
    .pipe_v(pv_a), .pipe_d(pd_a), .rdata(rdata_a), .rvalid(rvalid_a)
  );

  dpr_outsel u_out_b (
    .pipe(pipe_b), .oe_n(oe_n_b), .flow_v(fv_b), .flow_d(fd_b),
    .pipe_v(pv_b), .pipe_d(pd_b), .rdata(rdata_b), .rvalid(rvalid_b)
  );
endmodule

// File: rtl/dpr_sva.sv
`timescale 1ns/1ps
module dpr_sva (
  input logic        clk_a,
  input logic        rst_a_n,
  input logic        pipe_a,
  input logic        ce0_n_a,
  input logic        ce1_a,
  input logic        rw_a,
  input logic        oe_n_a,
  input logic [17:0] rdata_a,
  input logic [1:0]  rvalid_a,
  input logic        clk_b,
  input logic        rst_b_n,
  input logic        oe_n_b,
  input logic [17:0] rdata_b,
  input logic [1:0]  rvalid_b
);
  p_oe_blank_a_r7: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    oe_n_a |-> (rvalid_a == 2'b00 && rdata_a == 18'd0));

  p_oe_blank_b_r7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    oe_n_b |-> (rvalid_b == 2'b00 && rdata_b == 18'd0));

  p_zero_low_lane_r8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !rvalid_a[0] |-> rdata_a[8:0] == 9'd0);

  p_zero_high_lane_r8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !rvalid_a[1] |-> rdata_a[17:9] == 9'd0);

  p_write_silent_r6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (!pipe_a && !ce0_n_a && ce1_a && !rw_a) |=> (pipe_a || rvalid_a == 2'b00));

  p_desel_silent_r1: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (!pipe_a && !(!ce0_n_a && ce1_a)) |=> (pipe_a || rvalid_a == 2'b00));

  p_pipe_desel_r3: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (pipe_a && !(!ce0_n_a && ce1_a)) |-> ##2 (!pipe_a || rvalid_a == 2'b00));

  p_reset_quiet_r10: assert property (@(posedge clk_a)
    !rst_a_n |-> rvalid_a == 2'b00);
endmodule

bind dual_port_ram dpr_sva u_sva (.*);

// File: tb/dual_port_ram_bench.sv
`timescale 1ns/100ps
module dual_port_ram_bench;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;
  localparam int PER   = 4;

  logic clk_a = 0, clk_b = 0;
  always #2 clk_a = ~clk_a;
  initial begin #1; forever #2 clk_b = ~clk_b; end

  logic rst_a_n = 0, rst_b_n = 0;
  logic pipe_a = 0, ce0_n_a = 1, ce1_a = 0, rw_a = 1, oe_n_a = 0;
  logic pipe_b = 0, ce0_n_b = 1, ce1_b = 0, rw_b = 1, oe_n_b = 0;
  logic [1:0] lane_n_a = 0, lane_n_b = 0, rvalid_a, rvalid_b;
  logic [AW-1:0] addr_a = 0, addr_b = 0;
  logic [17:0] wdata_a = 0, wdata_b = 0, rdata_a, rdata_b;

  dual_port_ram #(.DEPTH(DEPTH)) u_dual_port_ram (.*);

  int checks = 0, fails = 0, edges_a = 0;
  logic [17:0] model [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) model[i] = '0;

  typedef struct { int due; logic [19:0] exp; string tag; } item_t;
  item_t sbq[$];
  item_t it;

  task automatic chk(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] expect_of(input logic [1:0] v, input logic [17:0] w);
    logic [17:0] d = '0;
    for (int l = 0; l < 2; l++) if (v[l]) d[l*9 +: 9] = w[l*9 +: 9];
    return {v, d};
  endfunction

  always @(posedge clk_a) edges_a <= edges_a + 1;

  // monitor: compares every due slot
  always @(posedge clk_a) begin
    #1;
    while (sbq.size() > 0 && sbq[0].due <= edges_a) begin
      it = sbq.pop_front();
      chk(it.due == edges_a && {rvalid_a, rdata_a} === it.exp, it.tag,
          {rvalid_a, rdata_a}, it.exp);
    end
  end

  // driver: one operation on port A, expected slot pushed to the scoreboard
  task automatic a_op(input bit rw, input bit c0n, input bit c1, input logic [1:0] ln,
                      input int adr, input logic [17:0] wd, input string tag);
    bit sel;
    logic [19:0] e;
    item_t n;
    @(negedge clk_a);
    ce0_n_a = c0n; ce1_a = c1; rw_a = rw; lane_n_a = ln; addr_a = adr[AW-1:0]; wdata_a = wd;
    sel = !c0n && c1;
    e = expect_of((sel && rw) ? ~ln : 2'b00, model[adr]);
    if (sel && !rw)
      for (int l = 0; l < 2; l++) if (!ln[l]) model[adr][l*9 +: 9] = wd[l*9 +: 9];
    n.due = edges_a + 1 + (pipe_a ? 1 : 0);
    n.exp = e;
    n.tag = tag;
    sbq.push_back(n);
  endtask

  task automatic a_idle();
    a_op(1'b1, 1'b1, 1'b0, 2'b00, 0, 18'd0, "R1 idle slot");
  endtask

  task automatic set_mode_a(input bit m);
    @(negedge clk_a); ce0_n_a = 1; ce1_a = 0;
    repeat (3) @(negedge clk_a);
    pipe_a = m;
  endtask

  task automatic b_read(input int adr, input string tag);
    logic [19:0] e;
    e = {2'b11, model[adr]};
    @(negedge clk_b);
    ce0_n_b = 0; ce1_b = 1; rw_b = 1; lane_n_b = 2'b00; addr_b = adr[AW-1:0];
    @(posedge clk_b); #1;
    if (pipe_b) chk(rvalid_b == 2'b00, {tag, " R3 not yet"}, {rvalid_b, rdata_b}, 20'd0);
    else        chk({rvalid_b, rdata_b} === e, {tag, " R2"}, {rvalid_b, rdata_b}, e);
    @(negedge clk_b); ce1_b = 0;
    @(posedge clk_b); #1;
    if (pipe_b) chk({rvalid_b, rdata_b} === e, {tag, " R3"}, {rvalid_b, rdata_b}, e);
    else        chk({rvalid_b, rdata_b} == 20'd0, {tag, " R1 blank after edge"}, {rvalid_b, rdata_b}, 20'd0);
    @(posedge clk_b); #1;
  endtask

  task automatic b_write(input int adr, input logic [1:0] ln, input logic [17:0] wd);
    @(negedge clk_b);
    ce0_n_b = 0; ce1_b = 1; rw_b = 0; lane_n_b = ln; addr_b = adr[AW-1:0]; wdata_b = wd;
    for (int l = 0; l < 2; l++) if (!ln[l]) model[adr][l*9 +: 9] = wd[l*9 +: 9];
    @(negedge clk_b); ce1_b = 0; rw_b = 1;
  endtask

  initial begin
    #(200000 * PER);
    fails++;
    $display("FAIL watchdog timeout (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_a);
    #0.5;
    chk(rvalid_a == 2'b00, "R10 port A quiet in reset", {rvalid_a, rdata_a}, 20'd0);
    chk(rvalid_b == 2'b00, "R10 port B quiet in reset", {rvalid_b, rdata_b}, 20'd0);
    rst_a_n = 1; rst_b_n = 1;
    repeat (2) @(negedge clk_a);

    // flow-through stream on port A
    a_op(1'b0, 1'b0, 1'b1, 2'b00, 5,    18'h1F0A3, "R5 R6 full write 5");
    a_op(1'b0, 1'b0, 1'b1, 2'b00, 700,  18'h2C3D4, "R5 R6 full write 700");
    a_op(1'b0, 1'b0, 1'b1, 2'b00, 3,    18'h0BEEF, "R5 R6 full write 3");
    a_op(1'b0, 1'b0, 1'b1, 2'b00, 1023, 18'h35A5A, "R5 R6 full write 1023");
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 1023, 18'd0, "R2 R11 read 1023");
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 5,    18'd0, "R2 R11 read 5");
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 700,  18'd0, "R2 R11 read 700");
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 3,    18'd0, "R2 R11 read 3");
    a_op(1'b0, 1'b0, 1'b1, 2'b01, 5,    18'h12345, "R5 upper-lane write 5");
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 5,    18'd0, "R5 masked result 5");
    a_op(1'b1, 1'b0, 1'b1, 2'b10, 700,  18'd0, "R4 R8 lower lane only");
    a_op(1'b1, 1'b0, 1'b1, 2'b01, 700,  18'd0, "R4 R8 upper lane only");
    a_op(1'b1, 1'b0, 1'b1, 2'b11, 700,  18'd0, "R4 both lanes off");
    a_op(1'b1, 1'b1, 1'b1, 2'b00, 3,    18'd0, "R1 ce0_n high");
    a_op(1'b1, 1'b0, 1'b0, 2'b00, 3,    18'd0, "R1 ce1 low");
    a_op(1'b0, 1'b1, 1'b0, 2'b00, 3,    18'h00001, "R1 deselected write");
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 3,    18'd0, "R1 word 3 unchanged");
    a_op(1'b0, 1'b0, 1'b1, 2'b00, 9,    18'h2AAAA, "R6 write slot silent");
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 9,    18'd0, "R6 readback 9");

    // combinational output enable
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 700,  18'd0, "R7 read before oe test");
    @(posedge clk_a); #1.5;
    oe_n_a = 1; #0.5;
    chk({rvalid_a, rdata_a} == 20'd0, "R7 oe_n high blanks at once", {rvalid_a, rdata_a}, 20'd0);
    oe_n_a = 0; #0.3;
    chk({rvalid_a, rdata_a} === {2'b11, model[700]}, "R7 oe_n low restores at once",
        {rvalid_a, rdata_a}, {2'b11, model[700]});
    a_idle();

    // pipelined stream on port A
    set_mode_a(1'b1);
    a_op(1'b0, 1'b0, 1'b1, 2'b00, 20,  18'h3C001, "R3 R6 write 20");
    a_op(1'b0, 1'b0, 1'b1, 2'b00, 512, 18'h00FF0, "R3 R6 write 512");
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 512, 18'd0, "R3 R11 read 512");
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 20,  18'd0, "R3 R11 read 20");
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 1023, 18'd0, "R3 R11 read 1023");
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 5,   18'd0, "R3 read 5");
    a_idle();
    a_op(1'b1, 1'b0, 1'b1, 2'b10, 20,  18'd0, "R3 R4 lower lane pipelined");
    a_op(1'b0, 1'b0, 1'b1, 2'b00, 40,  18'h1B2C3, "R3 R6 write 40");
    a_idle();
    set_mode_a(1'b1);

    // cross-port sharing
    b_read(700, "R9 B flow reads A word");
    pipe_b = 1;
    b_read(20, "R9 B pipelined reads A word");
    b_write(40, 2'b10, 18'h00155);
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 40, 18'd0, "R9 R5 A reads B lane write");
    a_idle();
    b_write(77, 2'b00, 18'h2468A);
    pipe_b = 0;
    b_read(77, "R9 B flow reads own write");
    set_mode_a(1'b0);
    a_op(1'b1, 1'b0, 1'b1, 2'b00, 77, 18'd0, "R9 A reads B full write");
    a_idle();

    repeat (6) @(negedge clk_a);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule